// File: doc/BRIEF.md
# Multi-Slot Pulser Firing Sequencer

This block steps a set of transducers through up to eight firing time slots. Each of four transducers has a setup byte. The byte enables the transducer, places it in one slot and names the pulser channel that fires for it. Several transducers can therefore fire together in one slot, fire one after another in separate slots, or be routed to a different pulser channel for pitch-catch work. A slot may also be left empty.

As timing master (`isMaster` = 1), the block paces the sequence itself. For each slot it drives `syncOutN` low for a programmable width, waits a programmable post-sync delay, raises the selected `fire` lines for a programmable width, and then waits a programmable rep-rate gap before moving to the next slot. As slave (`isMaster` = 0), it waits for each falling edge on `extSyncN`, applies the same post-sync delay and fires for a single clock. It never drives the sync output in slave mode.

All durations are counted in system clocks, and a programmed value of zero acts as one clock. Sequencing runs only while `runEn` is high.

Top module: `fire_seq_top`

## Requirements
- R1: The active slot count is `numSlots` clamped to 1..8, with 0 read as 1 and values above 8 read as 8. `slotIdx` runs 0, 1, … up to count-1 and then returns to 0.
- R2: Transducer t uses setup byte `xdcrCfg[8t+7:8t]`. Bit 3 enables it, bits 2:0 give its slot (0..7), and bits 7:4 give its pulser channel. While firing slot s, `fire` has bit c set exactly when some enabled transducer is assigned slot s and channel c. Zero, one or several channels may be set.
- R3: A channel field value of 8 to 15 fires no channel for that transducer.
- R4: In master mode, each slot begins with `syncOutN` low for max(`syncWidth`,1) clocks. `fire` is never non-zero while `syncOutN` is low.
- R5: After sync is generated (master) or detected (slave), `syncOutN` stays high and `fire` stays zero for max(`postDelay`,1) clocks before firing.
- R6: In master mode, `fire` holds the slot's mask for max(`fireWidth`,1) clocks.
- R7: In master mode, a gap of max(`repDelay`,1) clocks with all outputs inactive follows each fire pulse. After the gap, the next slot's sync pulse starts.
- R8: In slave mode, `extSyncN` passes through a two-flop synchronizer. A low level first driven in a given cycle leaves two quiet cycles, then the post-sync delay, then a one-clock fire pulse. `syncOutN` stays high throughout slave mode.
- R9: In slave mode, each falling edge of `extSyncN` starts exactly one slot. Holding the input low does not start another slot. After the fire pulse, `slotIdx` advances to the next slot.
- R10: When `runEn` is low, the block is idle with `syncOutN` = 1, `fire` = 0 and `slotIdx` = 0, from the clock after `runEn` falls. A later start begins at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Sequencing enable |
| isMaster | input | 1 | 1: pace slots internally and drive sync; 0: follow external sync |
| numSlots | input | 4 | Active slot count (clamped to 1..8) |
| xdcrCfg | input | 32 | Four transducer setup bytes: enable, slot, channel |
| repDelay | input | 32 | Rep-rate gap between slots, in clocks (master) |
| fireWidth | input | 32 | Fire pulse width, in clocks (master) |
| syncWidth | input | 16 | Sync output low width, in clocks (master) |
| postDelay | input | 16 | Delay from sync to fire, in clocks |
| extSyncN | input | 1 | External sync, falling edge triggers a slot (slave) |
| syncOutN | output | 1 | Sync output, active low (master) |
| fire | output | 8 | Pulser channel fire lines |
| slotIdx | output | 3 | Current slot index |

## Verification
In master mode, the sync pulse shows at the first sample after the clock edge that sees `runEn` high. From there each phase lasts exactly its programmed count (sync, post-delay, fire, gap), so the bench walks the expected phase lengths and compares every sample in each phase. In slave mode, firing follows a low `extSyncN` after two synchronizer samples plus the post-delay, and lasts one sample. After that, `slotIdx` shows the next slot. Stopping takes effect at the sample after the edge that sees `runEn` low. All samples are taken on the falling clock edge, and inputs are driven there as well.

// File: rtl/fire_seq_pkg.sv
package fire_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SYNC, ST_POST, ST_FIRE, ST_GAP, ST_WAIT
  } seqState_t;

  typedef enum logic [2:0] {
    LD_SYNC, LD_POST, LD_FIRE, LD_GAP, LD_ONE
  } loadSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     cntLoad;
    loadSel_t loadSel;
    logic     slotNext;
    logic     slotClear;
    logic     syncLow;
    logic     fireOn;
  } dpCtrl_t;

endpackage

// File: rtl/fire_seq_ctrl.sv
module fire_seq_ctrl
  import fire_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    runEn,
  input  logic    isMaster,
  input  logic    cntZero,
  input  logic    trigFall,
  output dpCtrl_t ctl
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState     = state;
    ctl           = '0;
    ctl.loadSel   = LD_ONE;
    ctl.syncLow   = (state == ST_SYNC);
    ctl.fireOn    = (state == ST_FIRE);
    if (!runEn) begin
      nextState     = ST_IDLE;
      ctl.slotClear = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (isMaster) begin
            nextState   = ST_SYNC;
            ctl.cntLoad = 1'b1;
            ctl.loadSel = LD_SYNC;
          end else begin
            nextState = ST_WAIT;
          end
        end
        ST_SYNC: if (cntZero) begin
          nextState   = ST_POST;
          ctl.cntLoad = 1'b1;
          ctl.loadSel = LD_POST;
        end
        ST_POST: if (cntZero) begin
          nextState   = ST_FIRE;
          ctl.cntLoad = 1'b1;
          ctl.loadSel = isMaster ? LD_FIRE : LD_ONE;
        end
        ST_FIRE: if (cntZero) begin
          if (isMaster) begin
            nextState   = ST_GAP;
            ctl.cntLoad = 1'b1;
            ctl.loadSel = LD_GAP;
          end else begin
            nextState    = ST_WAIT;
            ctl.slotNext = 1'b1;
          end
        end
        ST_GAP: if (cntZero) begin
          nextState    = ST_SYNC;
          ctl.cntLoad  = 1'b1;
          ctl.loadSel  = LD_SYNC;
          ctl.slotNext = 1'b1;
        end
        ST_WAIT: if (trigFall) begin
          nextState   = ST_POST;
          ctl.cntLoad = 1'b1;
          ctl.loadSel = LD_POST;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  // R5: the post-sync delay is only entered from a sync phase or a detected trigger
  p_post_follows_sync_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POST && $past(state) != ST_POST) |->
      ($past(state) == ST_SYNC || $past(state) == ST_WAIT));

  // R10: run enable low always lands in idle
  p_stop_to_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> state == ST_IDLE);

endmodule

// File: rtl/fire_seq_dp.sv
module fire_seq_dp
  import fire_seq_pkg::*;
#(
  parameter int NUM_XDCR  = 4,
  parameter int NUM_CHAN  = 8,
  parameter int MAX_SLOTS = 8,
  parameter int REP_W     = 32,
  parameter int FIRE_W    = 32,
  parameter int SYNC_W    = 16,
  parameter int POST_W    = 16,
  localparam int CFG_W    = 8,
  localparam int SLOT_W   = $clog2(MAX_SLOTS),
  localparam int CH_W     = $clog2(NUM_CHAN)
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  dpCtrl_t                   ctl,
  input  logic [SLOT_W:0]           numSlots,
  input  logic [NUM_XDCR*CFG_W-1:0] xdcrCfg,
  input  logic [REP_W-1:0]          repDelay,
  input  logic [FIRE_W-1:0]         fireWidth,
  input  logic [SYNC_W-1:0]         syncWidth,
  input  logic [POST_W-1:0]         postDelay,
  input  logic                      extSyncN,
  output logic                      cntZero,
  output logic                      trigFall,
  output logic [SLOT_W-1:0]         slotIdx,
  output logic [NUM_CHAN-1:0]       fire,
  output logic                      syncOutN
);

  localparam int W_A   = (REP_W > FIRE_W) ? REP_W : FIRE_W;
  localparam int W_B   = (SYNC_W > POST_W) ? SYNC_W : POST_W;
  localparam int CNT_W = (W_A > W_B) ? W_A : W_B;

  // external sync: two-flop synchronizer plus edge history
  logic syncMeta, syncStable, syncPrev;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncMeta   <= 1'b1;
      syncStable <= 1'b1;
      syncPrev   <= 1'b1;
    end else begin
      syncMeta   <= extSyncN;
      syncStable <= syncMeta;
      syncPrev   <= syncStable;
    end
  end
  assign trigFall = syncPrev & ~syncStable;

  // slot counter with clamped wrap point
  logic [SLOT_W:0]   effSlots, lastWide;
  logic [SLOT_W-1:0] lastSlot;
  always_comb begin
    if (numSlots == '0)                             effSlots = (SLOT_W+1)'(1);
    else if (numSlots > (SLOT_W+1)'(MAX_SLOTS))     effSlots = (SLOT_W+1)'(MAX_SLOTS);
    else                                            effSlots = numSlots;
    lastWide = effSlots - (SLOT_W+1)'(1);
    lastSlot = lastWide[SLOT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.slotClear) slotIdx <= '0;
    else if (ctl.slotNext)      slotIdx <= (slotIdx >= lastSlot) ? '0 : slotIdx + 1'b1;
  end

  // phase duration counter
  logic [CNT_W-1:0] cnt, ldVal, loadVal;
  always_comb begin
    unique case (ctl.loadSel)
      LD_SYNC: ldVal = CNT_W'(syncWidth);
      LD_POST: ldVal = CNT_W'(postDelay);
      LD_FIRE: ldVal = CNT_W'(fireWidth);
      LD_GAP:  ldVal = CNT_W'(repDelay);
      default: ldVal = '0;
    endcase
    loadVal = (ldVal == '0) ? '0 : ldVal - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)              cnt <= '0;
    else if (ctl.cntLoad)   cnt <= loadVal;
    else if (cnt != '0)     cnt <= cnt - CNT_W'(1);
  end
  assign cntZero = (cnt == '0);

  // fire mask decode from transducer setup bytes
  logic [NUM_CHAN-1:0] fireMask;
  always_comb begin
    fireMask = '0;
    for (int t = 0; t < NUM_XDCR; t++) begin
      logic [CFG_W-1:0] cfgByte;
      cfgByte = xdcrCfg[t*CFG_W +: CFG_W];
      if (cfgByte[3] && (cfgByte[SLOT_W-1:0] == slotIdx) &&
          (cfgByte[7:4] < 4'(NUM_CHAN)))
        fireMask[cfgByte[4 +: CH_W]] = 1'b1;
    end
  end

  assign fire     = ctl.fireOn ? fireMask : '0;
  assign syncOutN = ~ctl.syncLow;

  // R1: an advanced slot stays inside the active range
  p_slot_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.slotNext && !ctl.slotClear) |=> ({1'b0, slotIdx} < $past(effSlots)));

  // R6: the phase counter steps down by one between loads
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.cntLoad && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));

  // R9: one detected edge per low pulse
  p_trig_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    trigFall |=> !trigFall);

endmodule

// File: rtl/fire_seq_top.sv
module fire_seq_top
  import fire_seq_pkg::*;
#(
  parameter int NUM_XDCR  = 4,
  parameter int NUM_CHAN  = 8,
  parameter int MAX_SLOTS = 8,
  parameter int REP_W     = 32,
  parameter int FIRE_W    = 32,
  parameter int SYNC_W    = 16,
  parameter int POST_W    = 16,
  localparam int SLOT_W   = $clog2(MAX_SLOTS)
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  runEn,
  input  logic                  isMaster,
  input  logic [SLOT_W:0]       numSlots,
  input  logic [NUM_XDCR*8-1:0] xdcrCfg,
  input  logic [REP_W-1:0]      repDelay,
  input  logic [FIRE_W-1:0]     fireWidth,
  input  logic [SYNC_W-1:0]     syncWidth,
  input  logic [POST_W-1:0]     postDelay,
  input  logic                  extSyncN,
  output logic                  syncOutN,
  output logic [NUM_CHAN-1:0]   fire,
  output logic [SLOT_W-1:0]     slotIdx
);

  dpCtrl_t ctl;
  logic    cntZero, trigFall;

  fire_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .runEn    (runEn),
    .isMaster (isMaster),
    .cntZero  (cntZero),
    .trigFall (trigFall),
    .ctl      (ctl)
  );

  fire_seq_dp #(
    .NUM_XDCR (NUM_XDCR),
    .NUM_CHAN (NUM_CHAN),
    .MAX_SLOTS(MAX_SLOTS),
    .REP_W    (REP_W),
    .FIRE_W   (FIRE_W),
    .SYNC_W   (SYNC_W),
    .POST_W   (POST_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .numSlots (numSlots),
    .xdcrCfg  (xdcrCfg),
    .repDelay (repDelay),
    .fireWidth(fireWidth),
    .syncWidth(syncWidth),
    .postDelay(postDelay),
    .extSyncN (extSyncN),
    .cntZero  (cntZero),
    .trigFall (trigFall),
    .slotIdx  (slotIdx),
    .fire     (fire),
    .syncOutN (syncOutN)
  );

  // R4: sync and fire never overlap
  p_fire_sync_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(!syncOutN && (fire != '0)));

  // R10: stopping quiets every output on the next clock
  p_idle_after_stop_r10: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (syncOutN && fire == '0 && slotIdx == '0));

  // R8: slave fire pulses last a single clock
  p_slave_single_fire_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!isMaster && fire != '0) |=> fire == '0);

endmodule

// File: tb/sim_fire_seq_top.sv
module sim_fire_seq_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        runEn, isMaster, extSyncN;
  logic [3:0]  numSlots;
  logic [31:0] xdcrCfg, repDelay, fireWidth;
  logic [15:0] syncWidth, postDelay;
  logic        syncOutN;
  logic [7:0]  fire;
  logic [2:0]  slotIdx;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fire_seq_top u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .isMaster(isMaster),
    .numSlots(numSlots), .xdcrCfg(xdcrCfg), .repDelay(repDelay),
    .fireWidth(fireWidth), .syncWidth(syncWidth), .postDelay(postDelay),
    .extSyncN(extSyncN), .syncOutN(syncOutN), .fire(fire), .slotIdx(slotIdx)
  );

  function automatic int dur(longint v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  function automatic int effN(int n);
    if (n == 0) return 1;
    if (n > 8)  return 8;
    return n;
  endfunction

  // R2/R3 expected fire mask for a slot
  function automatic logic [7:0] expMask(logic [31:0] c, int s);
    logic [7:0] m = '0;
    for (int t = 0; t < 4; t++) begin
      logic [7:0] b;
      b = c[t*8 +: 8];
      if (b[3] && (int'(b[2:0]) == s) && (b[7:4] < 4'd8)) m[b[6:4]] = 1'b1;
    end
    return m;
  endfunction

  task automatic expectPhase(int n, logic eSync, logic [7:0] eFire, int eSlot, string req);
    int bad = 0;
    logic aSync; logic [7:0] aFire; logic [2:0] aSlot;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (syncOutN !== eSync || fire !== eFire || slotIdx !== eSlot[2:0]) begin
        if (bad == 0) begin aSync = syncOutN; aFire = fire; aSlot = slotIdx; end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: got sync=%b fire=%h slot=%0d, expected sync=%b fire=%h slot=%0d",
               req, aSync, aFire, aSlot, eSync, eFire, eSlot);
    end
  endtask

  // master run from idle; caller is at a negedge with config set
  task automatic runMaster(int nObs);
    int e = effN(int'(numSlots));
    runEn = 1'b1;
    for (int k = 0; k < nObs; k++) begin
      int s = k % e;
      expectPhase(dur(syncWidth), 1'b0, 8'h00, s, "R4 sync low width");
      expectPhase(dur(postDelay), 1'b1, 8'h00, s, "R5 post-sync delay");
      expectPhase(dur(fireWidth), 1'b1, expMask(xdcrCfg, s), s, "R2 R3 R6 fire mask and width");
      expectPhase(dur(repDelay),  1'b1, 8'h00, s, "R7 R1 rep gap and slot order");
    end
    runEn = 1'b0;
    expectPhase(2, 1'b1, 8'h00, 0, "R10 stop to idle");
  endtask

  task automatic runSlave(int nObs, int holdLow);
    int e = effN(int'(numSlots));
    isMaster = 1'b0;
    runEn    = 1'b1;
    expectPhase(2, 1'b1, 8'h00, 0, "R8 slave waits");
    for (int k = 0; k < nObs; k++) begin
      int s  = k % e;
      int sn = (k + 1) % e;
      extSyncN = 1'b0;
      expectPhase(2, 1'b1, 8'h00, s, "R8 sync latency");
      expectPhase(dur(postDelay), 1'b1, 8'h00, s, "R5 slave post delay");
      expectPhase(1, 1'b1, expMask(xdcrCfg, s), s, "R8 R2 slave fire");
      expectPhase(holdLow, 1'b1, 8'h00, sn, "R9 held low no refire");
      extSyncN = 1'b1;
      expectPhase(3, 1'b1, 8'h00, sn, "R9 release");
    end
    runEn = 1'b0;
    expectPhase(1, 1'b1, 8'h00, 0, "R10 slave stop");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; runEn = 1'b0; isMaster = 1'b1; extSyncN = 1'b1;
    numSlots = 4'd4; xdcrCfg = '0; repDelay = '0; fireWidth = '0;
    syncWidth = '0; postDelay = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expectPhase(2, 1'b1, 8'h00, 0, "R10 reset state");

    // directed: four sequential transducers, remapped channels
    xdcrCfg = {8'h3B, 8'h5A, 8'h79, 8'h08};
    syncWidth = 16'd2; postDelay = 16'd3; fireWidth = 32'd2; repDelay = 32'd4;
    runMaster(6);

    // directed: two slots with simultaneous pairs, zero widths act as one
    numSlots = 4'd2;
    xdcrCfg = {8'h79, 8'h69, 8'h18, 8'h08};
    syncWidth = '0; postDelay = '0; fireWidth = '0; repDelay = '0;
    runMaster(4);

    // R3: invalid channels fire nothing; R1 zero count reads as one slot
    numSlots = 4'd0;
    xdcrCfg = {8'hF8, 8'h88, 8'h28, 8'h00};
    syncWidth = 16'd1; postDelay = 16'd1; fireWidth = 32'd1; repDelay = 32'd1;
    runMaster(3);

    // R1: count above eight clamps to eight, empty slots allowed
    numSlots = 4'd12;
    xdcrCfg = {8'h7F, 8'h4C, 8'h1A, 8'h09};
    runMaster(10);

    // R10: stop in the middle of a fire pulse, restart at slot 0
    numSlots = 4'd3;
    xdcrCfg = {8'h00, 8'h00, 8'h29, 8'h18};
    syncWidth = 16'd1; postDelay = 16'd1; fireWidth = 32'd6; repDelay = 32'd1;
    runEn = 1'b1;
    expectPhase(1, 1'b0, 8'h00, 0, "R4 start sync");
    expectPhase(1, 1'b1, 8'h00, 0, "R5 start delay");
    expectPhase(2, 1'b1, 8'h02, 0, "R6 partial fire");
    runEn = 1'b0;
    expectPhase(1, 1'b1, 8'h00, 0, "R10 mid-fire stop");
    runMaster(2);

    // constrained random master runs
    for (int it = 0; it < 6; it++) begin
      numSlots  = 4'($urandom_range(1, 8));
      xdcrCfg   = $urandom;
      syncWidth = 16'($urandom_range(0, 5));
      postDelay = 16'($urandom_range(0, 5));
      fireWidth = 32'($urandom_range(0, 5));
      repDelay  = 32'($urandom_range(0, 6));
      runMaster(effN(int'(numSlots)) + 2);
    end

    // slave runs: directed then random
    numSlots = 4'd3;
    xdcrCfg = {8'h00, 8'h7A, 8'h29, 8'h18};
    postDelay = 16'd2;
    runSlave(5, 6);
    for (int it = 0; it < 3; it++) begin
      numSlots  = 4'($urandom_range(1, 8));
      xdcrCfg   = $urandom;
      postDelay = 16'($urandom_range(0, 4));
      runSlave(effN(int'(numSlots)) + 1, $urandom_range(1, 5));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule